// File: doc/BRIEF.md
# I2C Burst Master with Register Window

This block is an I2C bus master that software drives through a small byte-wide register window. The host loads a slave address byte, a byte count and up to sixteen payload bytes, then writes one control byte to launch a burst. The block then runs the whole exchange without further help. It issues a START, shifts out the address byte, and moves every payload byte between the internal buffer and the bus. When it finishes it records either completion or an error in a status register.

After a burst the bus is left owned, with SCL held low. A later control write either launches another burst, which begins with a repeated START, or releases the bus with a STOP. SCL and SDA are open-drain. The block only ever pulls a line low, and it reads the resolved line levels back through two inputs. The bit rate is fixed at one quarter-period of `QDIV` system clocks, so each bit takes `4*QDIV` clocks.

Top module: `i2c_burst_master`

## Requirements
- R1: After reset, the byte count, status, slave address and all sixteen buffer bytes read as 0, `busy` is 0 and neither line is pulled low.
- R2: Register offsets are 0 for the byte count (4 bits, upper bits read 0), 1 for control (reads 0), 2 for status on read and error-reset on write, 3 for the slave address byte, and 4 to 19 for buffer entries 0 to 15. Any other offset reads 0.
- R3: A control write with bit 0 (enable) = 1 and bit 2 (start) = 1 launches a burst and raises `busy` on the next cycle. A control write with enable = 1 and start = 0, or with start = 1 and enable = 0 as a launch, starts nothing.
- R4: A write burst (address bit 0 = 0) sends the address byte and then count+1 bytes from buffer entry 0 upward, MSB first. On success the status reads 0x08 (bit 3 = complete, bit 2 = error clear).
- R5: A read burst (address bit 0 = 1) stores the received bytes into buffer entries 0 upward. The master ACKs every byte except the last, which it NACKs. Buffer entries beyond the burst keep their contents.
- R6: A NACK on the address byte sets status bit 2, moves no payload bytes and ends the burst.
- R7: A NACK on a written payload byte sets status bit 2 and sends no further bytes.
- R8: A control write with enable = 0 while idle clears status bit 2 and, if the bus is owned, issues a STOP (SDA rises while SCL is high).
- R9: A write to offset 2 with bit 2 = 0 clears status bit 2. With bit 2 = 1 it has no effect.
- R10: `busy` stays 1 from the launch until the cycle in which complete or error is recorded, which is `(4 + 36*(bytes+1))*QDIV` clocks after launch for a successful write burst. Control writes while `busy` (or while a STOP is running) are ignored.
- R11: If an error-reset write lands in the same cycle that the sequencer records an error, the error bit stays set.
- R12: Outside START and STOP conditions, SDA changes only while SCL is low, and each burst produces exactly one START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-byte register write strobe |
| wr_addr | input | AW | Register offset for writes |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | AW | Register offset for reads |
| rd_data | output | 8 | Read data byte (combinational from rd_addr) |
| busy | output | 1 | Burst in progress |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
The host's error-reset write and the sequencer's error recording both write the same status bit, and they can fall in the same clock edge. The bench launches a burst toward an absent slave and counts clocks from the launch edge to the edge that ends the address acknowledge slot, 40 quarter-periods later. It times an error-reset write to land exactly on that edge and expects status 0x0C to survive, then shows that an error-reset write in a later cycle does clear the bit. The same launch-relative counting pins the cycle in which `busy` falls on a successful burst and checks that a control write injected mid-burst neither stops nor disturbs it.

// File: rtl/i2c_burst_master.sv
module i2c_burst_master #(
  parameter int QDIV = 4,
  parameter int NBUF = 16,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low,
  output logic          sda_low
);
  localparam int CW = $clog2(NBUF);
  localparam int DW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [AW-1:0] A_CNT = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);
  localparam logic [AW-1:0] A_STS = AW'(2);
  localparam logic [AW-1:0] A_SLV = AW'(3);
  localparam logic [AW-1:0] A_BUF = AW'(4);
  localparam logic [AW-1:0] A_END = AW'(4 + NBUF);

  typedef enum logic [2:0] {IDLE, START, ADDR, DATA, STOP} st_t;

  st_t           st;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt_r, byten;
  logic [7:0]    slv_r, shreg;
  logic [7:0]    buf_r [NBUF];
  logic          done_r, err_r, rnw_q, ack_bad, held;
  logic [DW-1:0] div;

  wire tick      = div == DW'(QDIV - 1);
  wire host_ctl  = wr_en && wr_addr == A_CTL && st == IDLE;
  wire go        = host_ctl && wr_data[0] && wr_data[2];
  wire halt      = host_ctl && !wr_data[0];
  wire buf_wr    = wr_en && wr_addr >= A_BUF && wr_addr < A_END;
  wire [AW-1:0] widx = wr_addr - A_BUF;
  wire [AW-1:0] ridx = rd_addr - A_BUF;
  wire rd_phase  = st == DATA && rnw_q;
  wire last_byte = byten == cnt_r;
  wire unused_scl = scl_in;

  assign busy = st == START || st == ADDR || st == DATA;

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == A_CNT) rd_data = 8'(cnt_r);
    else if (rd_addr == A_STS) rd_data = {4'b0, done_r, err_r, 2'b0};
    else if (rd_addr == A_SLV) rd_data = slv_r;
    else if (rd_addr >= A_BUF && rd_addr < A_END) rd_data = buf_r[ridx[CW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; q <= '0; bitn <= '0; cnt_r <= '0; byten <= '0;
      slv_r <= '0; shreg <= '0; done_r <= 1'b0; err_r <= 1'b0;
      rnw_q <= 1'b0; ack_bad <= 1'b0; held <= 1'b0; div <= '0;
      scl_low <= 1'b0; sda_low <= 1'b0;
      for (int i = 0; i < NBUF; i++) buf_r[i] <= '0;
    end else begin
      div <= (go || (halt && held) || tick) ? '0 : div + DW'(1);
      if (wr_en && wr_addr == A_CNT) cnt_r <= wr_data[CW-1:0];
      if (wr_en && wr_addr == A_SLV) slv_r <= wr_data;
      if (buf_wr) buf_r[widx[CW-1:0]] <= wr_data;
      if (wr_en && wr_addr == A_STS && !wr_data[2]) err_r <= 1'b0;
      if (halt) err_r <= 1'b0;
      unique case (st)
        IDLE: begin
          if (go) begin
            st <= START; q <= '0; sda_low <= 1'b0; rnw_q <= slv_r[0];
          end else if (halt && held) begin
            st <= STOP; q <= '0; sda_low <= 1'b1;
          end
        end
        START: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: scl_low <= 1'b0;
            2'd1: sda_low <= 1'b1;
            2'd2: ;
            2'd3: begin st <= ADDR; scl_low <= 1'b1; bitn <= '0; shreg <= slv_r; end
          endcase
        end
        ADDR, DATA: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= (bitn == 4'd8) ? (rd_phase && !last_byte)
                                            : (rd_phase ? 1'b0 : !shreg[7]);
            2'd1: scl_low <= 1'b0;
            2'd2: begin
              if (bitn == 4'd8) ack_bad <= sda_in;
              else begin
                shreg <= {shreg[6:0], sda_in};
                if (rd_phase && bitn == 4'd7) buf_r[byten] <= {shreg[6:0], sda_in};
              end
            end
            2'd3: begin
              scl_low <= 1'b1;
              bitn <= bitn + 4'd1;
              if (bitn == 4'd8) begin
                bitn <= '0;
                if (ack_bad && !rd_phase) begin
                  st <= IDLE; held <= 1'b1; err_r <= 1'b1;
                end else if (st == ADDR) begin
                  st <= DATA; byten <= '0; shreg <= buf_r[0];
                end else if (last_byte) begin
                  st <= IDLE; held <= 1'b1; done_r <= 1'b1; err_r <= 1'b0;
                end else begin
                  byten <= byten + CW'(1); shreg <= buf_r[byten + CW'(1)];
                end
              end
            end
          endcase
        end
        STOP: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: scl_low <= 1'b0;
            2'd1: sda_low <= 1'b0;
            2'd2: ;
            2'd3: begin st <= IDLE; held <= 1'b0; end
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_sda_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ADDR || st == DATA) && $past(st) == st && !scl_low && $past(!scl_low))
      |-> $stable(sda_low));

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_r || err_r));

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  assert_errclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STS && !wr_data[2] && !busy) |=> !err_r);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && held) |=> (st == STOP && !err_r));
endmodule

// File: tb/sim_i2c_burst_master.sv
module sim_i2c_burst_master;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic busy, scl_low, sda_low;
  logic slv_low = 1'b0;
  wire scl = !scl_low;
  wire sda = !(sda_low || slv_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_burst_master #(.QDIV(QD), .NBUF(16), .AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .scl_in(scl), .sda_in(sda), .scl_low(scl_low), .sda_low(sda_low));

  int total = 0, fails = 0;
  int pushed = 0, popped = 0;
  logic [4:0] sb_a[$];
  logic [7:0] sb_e[$];
  int sb_r[$];

  // slave model
  int phase = 0, bitc = 0, wptr = 0, rptr = 0, nack_at = -1, nmack = 0;
  int starts = 0, stops = 0;
  logic [7:0] sh = '0, cur = '0;
  logic rnw = 1'b0, mack = 1'b0;
  logic [7:0] wmem [16];
  logic [7:0] rmem [16];
  logic mlog [16];

  always @(negedge sda) if (scl === 1'b1) begin
    starts++; phase = 1; bitc = 0; wptr = 0; rptr = 0; slv_low = 1'b0;
  end
  always @(posedge sda) if (scl === 1'b1 && rst_n) begin
    stops++; phase = 0; slv_low = 1'b0;
  end
  always @(posedge scl) if (phase >= 1 && phase <= 3) begin
    if (bitc < 8) begin
      if (phase != 3) sh = {sh[6:0], sda};
    end else if (bitc == 8 && phase == 3) begin
      mack = sda; if (nmack < 16) mlog[nmack] = sda; nmack++;
    end
    bitc++;
  end
  always @(negedge scl) if (phase >= 1 && phase <= 3) begin
    if (bitc == 8) begin
      if (phase == 1) begin
        if (sh[7:1] == DEV) begin slv_low = 1'b1; rnw = sh[0]; end
        else begin slv_low = 1'b0; phase = 4; end
      end else if (phase == 2) begin
        wmem[wptr[3:0]] = sh; wptr++; slv_low = (nack_at != wptr - 1);
      end else slv_low = 1'b0;
    end else if (bitc == 9) begin
      bitc = 0;
      if (phase == 1 && rnw) begin
        phase = 3; cur = rmem[rptr[3:0]]; rptr++; slv_low = !cur[7];
      end else if (phase == 1 || phase == 2) begin
        phase = 2; slv_low = 1'b0;
      end else if (mack) begin
        phase = 4; slv_low = 1'b0;
      end else begin
        cur = rmem[rptr[3:0]]; rptr++; slv_low = !cur[7];
      end
    end else if (phase == 3 && bitc >= 1 && bitc <= 7) slv_low = !cur[7 - bitc];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected register values and compares
  initial forever begin
    wait (sb_a.size() > 0);
    @(negedge clk);
    rd_addr = sb_a[0];
    #1;
    total++;
    if (rd_data !== sb_e[0]) begin
      fails++;
      $display("FAIL R%0d reg 0x%0h actual=0x%0h expected=0x%0h",
               sb_r[0], sb_a[0], rd_data, sb_e[0]);
    end
    void'(sb_a.pop_front()); void'(sb_e.pop_front()); void'(sb_r.pop_front());
    popped++;
  end

  task automatic expect_reg(input logic [4:0] a, input logic [7:0] e, input int r);
    sb_a.push_back(a); sb_e.push_back(e); sb_r.push_back(r); pushed++;
    wait (popped == pushed);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=idle");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin wmem[i] = '0; rmem[i] = '0; mlog[i] = 1'b0; end
    rmem[0] = 8'hC3; rmem[1] = 8'h5A; rmem[2] = 8'hE1; rmem[3] = 8'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(busy == 1'b0 && scl_low == 1'b0 && sda_low == 1'b0, "R1 lines/busy",
          {busy, scl_low, sda_low}, 0);
    expect_reg(5'd0, 8'h00, 1); expect_reg(5'd2, 8'h00, 1); expect_reg(5'd3, 8'h00, 1);
    for (int i = 0; i < 16; i++) expect_reg(5'(4 + i), 8'h00, 1);

    // R2 register window
    wr(5'd0, 8'hFF); expect_reg(5'd0, 8'h0F, 2);
    wr(5'd3, 8'hA5); expect_reg(5'd3, 8'hA5, 2);
    for (int i = 0; i < 16; i++) wr(5'(4 + i), 8'(i * 17 + 3));
    for (int i = 0; i < 16; i++) expect_reg(5'(4 + i), 8'(i * 17 + 3), 2);
    expect_reg(5'd1, 8'h00, 2); expect_reg(5'd20, 8'h00, 2);

    // R3 non-launching control encodings
    wr(5'd3, 8'hA0); wr(5'd0, 8'h00);
    wr(5'd1, 8'h01); repeat (20) @(negedge clk);
    check(!busy && starts == 0, "R3 enable-only", starts, 0);
    wr(5'd1, 8'h04); repeat (20) @(negedge clk);
    check(!busy && starts == 0, "R3 start-only", starts, 0);

    // R4 write burst of 4 bytes, R10 exact busy window and ignored control write
    wr(5'd4, 8'h11); wr(5'd5, 8'h22); wr(5'd6, 8'h33); wr(5'd7, 8'h44);
    wr(5'd0, 8'h03);
    wr(5'd1, 8'h05);
    check(busy == 1'b1, "R3 launch", busy, 1);
    repeat (100) @(negedge clk);
    wr(5'd1, 8'h00);
    repeat (633) @(negedge clk);
    check(busy == 1'b1, "R10 busy before end", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R10 busy after end", busy, 0);
    check(stops == 0, "R10 ignored control write", stops, 0);
    expect_reg(5'd2, 8'h08, 4);
    check(wptr == 4, "R4 byte count", wptr, 4);
    check(wmem[0] == 8'h11 && wmem[1] == 8'h22 && wmem[2] == 8'h33 && wmem[3] == 8'h44,
          "R4 payload", {wmem[0], wmem[3]}, 16'h1144);
    wr(5'd1, 8'h00); repeat (40) @(negedge clk);
    check(stops == 1 && !scl_low && !sda_low, "R8 stop after write", stops, 1);

    // R5 read burst of 3 bytes
    wr(5'd3, 8'hA1); wr(5'd0, 8'h02); wr(5'd1, 8'h05);
    wait_idle();
    expect_reg(5'd4, 8'hC3, 5); expect_reg(5'd5, 8'h5A, 5); expect_reg(5'd6, 8'hE1, 5);
    expect_reg(5'd7, 8'h44, 5);
    expect_reg(5'd2, 8'h08, 5);
    check(nmack == 3 && mlog[0] == 1'b0 && mlog[1] == 1'b0 && mlog[2] == 1'b1,
          "R5 master ack pattern", {mlog[0], mlog[1], mlog[2]}, 3'b001);
    wr(5'd1, 8'h00); repeat (40) @(negedge clk);

    // R6 address NACK, R11 same-cycle error set vs error reset
    wr(5'd3, 8'h42); wr(5'd0, 8'h01); wr(5'd1, 8'h05);
    repeat (159) @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd2; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    check(busy == 1'b0, "R6 burst ended", busy, 0);
    expect_reg(5'd2, 8'h0C, 11);
    expect_reg(5'd2, 8'h0C, 6);
    check(wptr == 0, "R6 no payload moved", wptr, 0);
    // R9 error reset register
    wr(5'd2, 8'h04); expect_reg(5'd2, 8'h0C, 9);
    wr(5'd2, 8'h00); expect_reg(5'd2, 8'h08, 9);
    wr(5'd1, 8'h00); repeat (40) @(negedge clk);

    // R7 NACK on second payload byte, R8 stop clears error
    nack_at = 1;
    wr(5'd3, 8'hA0); wr(5'd0, 8'h03); wr(5'd1, 8'h05);
    wait_idle();
    expect_reg(5'd2, 8'h0C, 7);
    check(wptr == 2, "R7 abort after nack", wptr, 2);
    wr(5'd1, 8'h00); repeat (40) @(negedge clk);
    expect_reg(5'd2, 8'h08, 8);
    check(stops == 4, "R8 stop count", stops, 4);

    // R12 exactly one START per burst, no spurious conditions
    check(starts == 4, "R12 start count", starts, 4);
    summary();
  end
endmodule